// File: doc/BRIEF.md
# DDR Read Learning-Pattern Preamble Generator

This block sits on the memory side of a quad serial interface and drives a calibration pattern onto the data lanes during the last dummy clocks of a double-data-rate read. The host uses this pattern to find where the data eye opens and closes, and then sets its capture point for the rest of the transfer. The pattern is a programmable 8-bit value. It goes out one bit per half clock, so it fills the final four dummy clocks and ends exactly where the first data bit begins. The same bits appear on every lane that is active for the current width. All other lanes stay high-impedance. Before the pattern window the block does not drive any lane, because the host may still be driving the bus.

The command decoder presents the dummy phase as three signals: an active flag, the total dummy count (taken from the latency setting) and the index of the current dummy clock. The decoder presents them one clock ahead. The block registers its outputs, so the result for a phase indication that is sampled at a rising edge appears just after that edge. Each lane has two data outputs, one for the rising half of the clock and one for the falling half, plus an output enable. A double-data-rate output cell downstream serialises the two data bits.

Top module: `ddr_learn_preamble`

## Requirements
- R1: While `rst` is high, and after it is released with no dummy phase, every bit of `dq_oe`, `dq_rise` and `dq_fall` is 0.
- R2: The outputs for a phase indication sampled at a rising edge of `clk` appear just after that edge (one register stage).
- R3: A lane is driven only for a dummy clock whose remaining count, `dummy_total - dummy_idx`, lies between 1 and 4. Earlier dummy clocks leave every `dq_oe` bit at 0.
- R4: For remaining count m, let slot s = 4 - m. The rising-half bit is pattern bit 7-2s and the falling-half bit is pattern bit 6-2s, so the pattern goes out most significant bit first. With pattern 34h, the slots give rise/fall pairs 0/0, 1/1, 0/1, 0/0.
- R5: If `dummy_total` is below 4, only the last 2×`dummy_total` pattern bits are driven, and they still end on the last dummy clock.
- R6: `width_mode` selects the active lanes: 0 selects lane 0, 1 selects lanes 0 and 1, 2 selects all four lanes, and 3 (reserved) selects lane 0.
- R7: Every active lane carries the same bits. A lane that is not driven has its output enable and both data outputs at 0.
- R8: When `pat_en` is low, no lane is driven at any point in the dummy phase.
- R9: The pattern value and width mode are captured on the first dummy clock (index 0). Later changes to `pat_val` or `width_mode` within the same phase have no effect on the outputs.
- R10: When `cs_n` goes high, every output enable and data output reads 0 in that same cycle and stays 0 afterwards.
- R11: When `dummy_active` is low, or `dummy_idx` is not below `dummy_total`, the next cycle drives no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock (rising edge) |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| dummy_active | input | 1 | Decoder is in the dummy phase |
| dummy_total | input | CW (5) | Number of dummy clocks for this read |
| dummy_idx | input | CW (5) | Index of the current dummy clock, starting at 0 |
| pat_en | input | 1 | Enables the learning pattern |
| pat_val | input | PW (8) | Learning pattern value |
| width_mode | input | 2 | Lane width: 0 = x1, 1 = x2, 2 = x4, 3 = reserved (x1) |
| dq_rise | output | LANES (4) | Per-lane bit for the rising half clock |
| dq_fall | output | LANES (4) | Per-lane bit for the falling half clock |
| dq_oe | output | LANES (4) | Per-lane output enable |

## Verification
The assertions assume the following of the decoder:
- it raises `dummy_active` only with chip select low;
- it advances `dummy_idx` by one per clock, starting from 0;
- it holds `dummy_total` steady through a phase.

Under those assumptions, two properties are checked:
- driven lanes always form a contiguous group starting at lane 0;
- the enables fall away after chip select rises or after the phase ends.

The directed tasks generate exactly such index sequences. The only deliberate departures are a single out-of-range index and a mid-window chip-select release; after each of these the tasks return the bus to idle before the next scenario.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [1:0] {
    WM_X1  = 2'd0,
    WM_X2  = 2'd1,
    WM_X4  = 2'd2,
    WM_RSV = 2'd3
  } width_mode_e;

  // number of lanes driven for a width mode, bounded by the lanes present
  function automatic int lanes_for(input width_mode_e m, input int max_lanes);
    int n;
    case (m)
      WM_X2:   n = 2;
      WM_X4:   n = 4;
      default: n = 1;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

endpackage

// File: rtl/ppg_window.sv
// Decides whether the current dummy clock lies in the pattern window
// and which pattern slot it carries.
module ppg_window #(
  parameter int CW    = 5,
  parameter int SLOTS = 4,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          dummy_active,
  input  logic [CW-1:0] dummy_total,
  input  logic [CW-1:0] dummy_idx,
  output logic          in_win,
  output logic [SW-1:0] slot
);

  logic [CW-1:0] remaining;
  logic          idx_ok;

  always_comb begin
    idx_ok    = dummy_idx < dummy_total;
    remaining = dummy_total - dummy_idx;
    in_win    = dummy_active && idx_ok && (remaining <= CW'(SLOTS));
    slot      = SW'(CW'(SLOTS) - remaining);
  end

endmodule

// File: rtl/ppg_shift.sv
// Holds the captured pattern and picks the two bits for a slot.
module ppg_shift #(
  parameter int PW    = 8,
  localparam int SLOTS = PW / 2,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [PW-1:0] pat_in,
  input  logic [SW-1:0] slot,
  output logic          bit_rise,
  output logic          bit_fall
);

  logic [PW-1:0] pat_q;
  logic [PW-1:0] pat_eff;

  always_ff @(posedge clk) begin
    if (rst) pat_q <= '0;
    else if (capture) pat_q <= pat_in;
  end

  // bypass so the capture clock itself already uses the new value
  always_comb begin
    pat_eff  = capture ? pat_in : pat_q;
    bit_rise = pat_eff[PW - 1 - 2 * int'(slot)];
    bit_fall = pat_eff[PW - 2 - 2 * int'(slot)];
  end

  // R9: stored pattern only moves on a capture clock
  a_r9_pattern_held: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(pat_q));

endmodule

// File: rtl/ppg_lane_mask.sv
// Captures the width mode and turns it into a per-lane enable mask.
module ppg_lane_mask
  import ppg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [1:0]       mode_in,
  output logic [LANES-1:0] mask
);

  width_mode_e mode_q;
  width_mode_e mode_eff;
  int          n_active;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= WM_X1;
    else if (capture) mode_q <= width_mode_e'(mode_in);
  end

  always_comb begin
    mode_eff = capture ? width_mode_e'(mode_in) : mode_q;
    n_active = lanes_for(mode_eff, LANES);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (i < n_active);
  end

  // R6: lane 0 is part of every width
  a_r6_lane0_always: assert property (@(posedge clk) disable iff (rst)
    mask[0]);

endmodule

// File: rtl/ddr_learn_preamble.sv
module ddr_learn_preamble
  import ppg_pkg::*;
#(
  parameter int CW    = 5,
  parameter int PW    = 8,
  parameter int LANES = 4,
  localparam int SLOTS = PW / 2,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             dummy_active,
  input  logic [CW-1:0]    dummy_total,
  input  logic [CW-1:0]    dummy_idx,
  input  logic             pat_en,
  input  logic [PW-1:0]    pat_val,
  input  logic [1:0]       width_mode,
  output logic [LANES-1:0] dq_rise,
  output logic [LANES-1:0] dq_fall,
  output logic [LANES-1:0] dq_oe
);

  logic             in_win;
  logic [SW-1:0]    slot;
  logic             first_dummy;
  logic             bit_rise, bit_fall;
  logic [LANES-1:0] mask;
  logic             drive;
  logic [LANES-1:0] oe_q, rise_q, fall_q;

  assign first_dummy = dummy_active && !cs_n && (dummy_idx == '0);

  ppg_window #(.CW(CW), .SLOTS(SLOTS)) u_window (
    .dummy_active (dummy_active),
    .dummy_total  (dummy_total),
    .dummy_idx    (dummy_idx),
    .in_win       (in_win),
    .slot         (slot)
  );

  ppg_shift #(.PW(PW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .capture  (first_dummy),
    .pat_in   (pat_val),
    .slot     (slot),
    .bit_rise (bit_rise),
    .bit_fall (bit_fall)
  );

  ppg_lane_mask #(.LANES(LANES)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .capture (first_dummy),
    .mode_in (width_mode),
    .mask    (mask)
  );

  assign drive = in_win && pat_en && !cs_n;

  always_ff @(posedge clk) begin
    if (rst || !drive) begin
      oe_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      oe_q   <= mask;
      rise_q <= mask & {LANES{bit_rise}};
      fall_q <= mask & {LANES{bit_fall}};
    end
  end

  // chip select release drops the bus in the same cycle
  assign dq_oe   = oe_q & {LANES{!cs_n}};
  assign dq_rise = rise_q & dq_oe;
  assign dq_fall = fall_q & dq_oe;

  // R10: registered enables are clear one edge after chip select rises
  a_r10_cs_release: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (oe_q == '0));

  // R8: a disabled pattern never drives
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !pat_en |=> (oe_q == '0));

  // R11: no phase, no drive
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !dummy_active |=> (oe_q == '0));

  // R7: undriven lanes carry no data
  a_r7_data_gated: assert property (@(posedge clk) disable iff (rst)
    (((rise_q | fall_q) & ~oe_q) == '0));

  // R6: driven lanes form a group starting at lane 0
  a_r6_lanes_contiguous: assert property (@(posedge clk) disable iff (rst)
    ((oe_q & (oe_q + LANES'(1))) == '0));

  // R3: nothing is driven unless the previous edge saw a window clock
  a_r3_window_only: assert property (@(posedge clk) disable iff (rst)
    !in_win |=> (oe_q == '0));

endmodule

// File: tb/test_ddr_learn_preamble.sv
module test_ddr_learn_preamble;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;
  localparam int PW = 8;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             cs_n;
  logic             dummy_active;
  logic [CW-1:0]    dummy_total;
  logic [CW-1:0]    dummy_idx;
  logic             pat_en;
  logic [PW-1:0]    pat_val;
  logic [1:0]       width_mode;
  logic [LANES-1:0] dq_rise, dq_fall, dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr_learn_preamble #(.CW(CW), .PW(PW), .LANES(LANES)) i_ddr_learn_preamble (
    .clk (clk), .rst (rst), .cs_n (cs_n), .dummy_active (dummy_active),
    .dummy_total (dummy_total), .dummy_idx (dummy_idx), .pat_en (pat_en),
    .pat_val (pat_val), .width_mode (width_mode),
    .dq_rise (dq_rise), .dq_fall (dq_fall), .dq_oe (dq_oe)
  );

  task automatic check(input bit ok, input string req, input logic [11:0] act,
                       input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual oe/rise/fall=%03h expected=%03h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] m);
    case (m)
      2'd1:    return 4'b0011;
      2'd2:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  // expected {oe, rise, fall} for dummy clock k of a phase
  function automatic logic [11:0] expect_out(input int total, input int k, input bit en,
                                             input logic [7:0] p, input logic [1:0] m);
    int rem;
    int s;
    logic [3:0] mk;
    rem = total - k;
    mk  = lane_mask(m);
    if (!en || rem < 1 || rem > 4) return '0;
    s = 4 - rem;
    return {mk, p[7 - 2*s] ? mk : 4'b0, p[6 - 2*s] ? mk : 4'b0};
  endfunction

  function automatic logic [11:0] outs();
    return {dq_oe, dq_rise, dq_fall};
  endfunction

  task automatic go_idle();
    dummy_active = 1'b0;
    dummy_idx    = '0;
    cs_n         = 1'b0;
    @(posedge clk); @(negedge clk);
    check(outs() == '0, "R11 idle after phase", outs(), '0);
  endtask

  // one dummy phase; disturb=1 changes pattern and width after index 0 (R9);
  // abort_at >= 0 raises chip select during that clock (R10)
  task automatic run_phase(input string req, input int total, input logic [1:0] m,
                           input logic [7:0] p, input bit en, input bit disturb,
                           input int abort_at);
    dummy_total = CW'(total);
    pat_en      = en;
    for (int k = 0; k < total; k++) begin
      dummy_active = 1'b1;
      dummy_idx    = CW'(k);
      if (k == 0) begin
        pat_val    = p;
        width_mode = m;
      end else if (disturb) begin
        pat_val    = ~p;
        width_mode = 2'd0;
      end
      @(posedge clk); @(negedge clk);
      if (k == abort_at) begin
        check(outs() == expect_out(total, k, en, p, m), req, outs(), expect_out(total, k, en, p, m));
        cs_n = 1'b1;
        dummy_active = 1'b0;
        #1;
        check(outs() == '0, "R10 same-cycle release", outs(), '0);
        @(posedge clk); @(negedge clk);
        check(outs() == '0, "R10 stays released", outs(), '0);
        break;
      end
      check(outs() == expect_out(total, k, en, p, m), req, outs(), expect_out(total, k, en, p, m));
    end
    go_idle();
  endtask

  task automatic t_reset();
    rst = 1'b1; cs_n = 1'b0; dummy_active = 1'b1; dummy_total = 5'd4;
    dummy_idx = '0; pat_en = 1'b1; pat_val = 8'hFF; width_mode = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outs() == '0, "R1 during reset", outs(), '0);
    dummy_active = 1'b0;
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(outs() == '0, "R1 after reset", outs(), '0);
  endtask

  task automatic t_out_of_range();
    dummy_total  = 5'd6;
    dummy_active = 1'b1;
    dummy_idx    = 5'd8;
    pat_en = 1'b1; pat_val = 8'hFF; width_mode = 2'd2;
    @(posedge clk); @(negedge clk);
    check(outs() == '0, "R11 index beyond total", outs(), '0);
    go_idle();
  endtask

  initial begin
    t_reset();
    run_phase("R4 R2 x4 pattern 34h", 8, 2'd2, 8'h34, 1'b1, 1'b0, -1);
    run_phase("R3 R7 x2 pattern A5h", 6, 2'd1, 8'hA5, 1'b1, 1'b0, -1);
    run_phase("R6 x1 pattern C3h", 5, 2'd0, 8'hC3, 1'b1, 1'b0, -1);
    run_phase("R6 reserved mode", 4, 2'd3, 8'h96, 1'b1, 1'b0, -1);
    run_phase("R5 short latency 2", 2, 2'd2, 8'h1E, 1'b1, 1'b0, -1);
    run_phase("R5 short latency 1", 1, 2'd1, 8'h02, 1'b1, 1'b0, -1);
    run_phase("R8 pattern disabled", 7, 2'd2, 8'hFF, 1'b0, 1'b0, -1);
    run_phase("R9 late writes ignored", 10, 2'd2, 8'h5A, 1'b1, 1'b1, -1);
    run_phase("R10 abort mid window", 6, 2'd2, 8'hFF, 1'b1, 1'b0, 3);
    t_out_of_range();
    run_phase("R3 long latency 20", 20, 2'd2, 8'h69, 1'b1, 1'b0, -1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule